// File: doc/BRIEF.md
# Tone-Shift Receive Demodulator with Carrier Qualification

This block sits behind an ADC and a band-pass filter on the receive side of a two-tone frequency-shift-keyed modem. It takes signed digital samples, one per `sampleEn` strobe, and recovers a 1200 bit/s binary stream. A 1200 Hz tone is a mark (1) and a 2200 Hz tone is a space (0). It tells the two tones apart by measuring the time between sign changes of the input. A majority vote over the last few crossings smooths out that decision. The recovered stream keeps its UART framing: one start bit, eight data bits, parity and a stop bit. Deframing is left to a downstream UART.

A carrier-detect flag reports when a tone of enough amplitude is present. The amplitude measure is the largest sample magnitude seen over each window of one bit time. The flag uses two thresholds, a higher one to assert and a lower one to release, with a hold band between them. It also needs several consecutive qualifying windows before it changes state. While the flag is low, the data output idles at 1, so line noise cannot produce false start bits.

The receiver is active when the request-to-send input is high, or at any time the full-duplex input is high. The full-duplex case lets a local transmitter be looped back for self-test. Whenever the receiver goes from inactive to active, it spends a fixed number of bit windows settling before it may qualify a carrier. This makes the turnaround from transmit to receive slower than ordinary carrier acquisition.

Top module: `fskCarrierDemod`

## Requirements
- R1: While `carrierOk` is high, `rxBit` is 1 for a steady 1200 Hz input and 0 for a steady 2200 Hz input, once the tone has lasted two bit times. A bit time is `SAMPLES_PER_BIT` samples, 48 by default.
- R2: The receiver is active exactly when `reqSend` or `fullDuplex` is high. One clock after both are low, `carrierOk` is 0 and `rxBit` is 1, and they stay so while both remain low.
- R3: Suppose the receiver has been active for more than `TURN_BITS` bit windows. If a tone with peak magnitude at or above `HI_TH` (520) then appears, `carrierOk` is 1 within 6 bit times.
- R4: While `carrierOk` is high, if every window's peak magnitude drops below `LO_TH` (400), `carrierOk` is 0 within 6 bit times.
- R5: When the receiver becomes active with a valid tone already present, `carrierOk` stays 0 for the first `TURN_BITS` (4) bit windows and is 1 within 10 bit times.
- R6: `carrierOk` never rises while the input peak magnitude stays below `LO_TH`, and it never rises on a silent (all-zero) input.
- R7: A peak magnitude between `LO_TH` and `HI_TH` leaves `carrierOk` unchanged, whether it was high or low.
- R8: `rxBit` is 1 in every cycle in which `carrierOk` is 0, even when a low-amplitude space tone is present.
- R9: A framed all-ones character (start bit 0, eight 1 data bits, parity 1, stop 1) yields one low excursion on `rxBit` during the start bit. `rxBit` then stays at 1 through the later data bits.
- R10: After synchronous reset (`rst` high), `carrierOk` is 0 and `rxBit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Strobe marking a new input sample |
| sampleIn | input | SAMPLE_W | Filtered received signal, two's complement |
| reqSend | input | 1 | High selects receive mode |
| fullDuplex | input | 1 | High keeps the receiver active regardless of `reqSend` |
| carrierOk | output | 1 | Qualified carrier present |
| rxBit | output | 1 | Recovered data, 1 while no carrier is qualified |

## Verification
The carrier flag changes only one clock after the end of a bit window. Its bounds (6, 6 and 10 bit times) are therefore checked at the bound itself: the bench runs exactly that many samples after the stimulus and then samples the output. The flag is also sampled at 3 bit times after the receiver becomes active, where it must still be low because of the settle windows. A change of enable reaches the outputs one clock later, so the disable check looks at the very next cycle. Decoded data lags a tone change by up to two crossing intervals of the slower tone plus one register. Data is therefore checked only after two bit times of steady tone. The start-bit check watches every sample across the start bit and the following bit.

// File: rtl/fskDemodPkg.sv
package fskDemodPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // hold all measurement state at its idle value
    logic advance;  // consume the current sample
  } ctlStrobes_t;
endpackage

// File: rtl/fskDemodPath.sv
module fskDemodPath
  import fskDemodPkg::*;
#(
  parameter int SAMPLE_W        = 12,
  parameter int SAMPLES_PER_BIT = 48,
  parameter int LONG_HALF       = 18,
  parameter int MAJ_LEN         = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStrobes_t                strobe,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       winDone,
  output logic [SAMPLE_W-1:0]        winPeak,
  output logic                       toneLive,
  output logic                       toneBit
);
  localparam int CNT_W = $clog2(SAMPLES_PER_BIT + 1);
  localparam int ONES_W = $clog2(MAJ_LEN + 1);
  localparam logic [CNT_W-1:0] STALE = CNT_W'(SAMPLES_PER_BIT);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SAMPLES_PER_BIT - 1);
  localparam logic [CNT_W:0]   LONG  = (CNT_W + 1)'(LONG_HALF);

  logic                prevSign;
  logic [CNT_W-1:0]    gapCnt;
  logic [CNT_W-1:0]    winCnt;
  logic [SAMPLE_W-1:0] runMax;
  logic [MAJ_LEN-1:0]  hist;

  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] peakNow;
  logic                crossing;
  logic                intervalLong;
  logic [ONES_W-1:0]   ones;
  logic                majBit;

  always_comb begin
    mag          = sampleIn[SAMPLE_W-1] ? $unsigned(-sampleIn) : $unsigned(sampleIn);
    peakNow      = (mag > runMax) ? mag : runMax;
    crossing     = sampleIn[SAMPLE_W-1] != prevSign;
    intervalLong = ({1'b0, gapCnt} + 1'b1) >= LONG;
    ones = '0;
    for (int i = 0; i < MAJ_LEN; i++) ones = ones + ONES_W'(hist[i]);
    majBit   = ones > ONES_W'(MAJ_LEN / 2);
    toneLive = gapCnt < STALE;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      prevSign <= 1'b0;
      gapCnt   <= STALE;
      winCnt   <= '0;
      runMax   <= '0;
      hist     <= '1;
      winDone  <= 1'b0;
      winPeak  <= '0;
      toneBit  <= 1'b1;
    end else begin
      winDone <= 1'b0;
      toneBit <= majBit;
      if (strobe.advance) begin
        prevSign <= sampleIn[SAMPLE_W-1];
        if (crossing) begin
          hist   <= {hist[MAJ_LEN-2:0], intervalLong};
          gapCnt <= '0;
        end else if (gapCnt < STALE) begin
          gapCnt <= gapCnt + 1'b1;
        end
        if (winCnt == LAST) begin
          winCnt  <= '0;
          winDone <= 1'b1;
          winPeak <= peakNow;
          runMax  <= '0;
        end else begin
          winCnt <= winCnt + 1'b1;
          runMax <= peakNow;
        end
      end
    end
  end
endmodule

// File: rtl/fskDemodCtrl.sv
module fskDemodCtrl
  import fskDemodPkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int LO_TH     = 400,
  parameter int HI_TH     = 520,
  parameter int ON_BITS   = 3,
  parameter int OFF_BITS  = 3,
  parameter int TURN_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqSend,
  input  logic                fullDuplex,
  input  logic                sampleEn,
  input  logic                winDone,
  input  logic [SAMPLE_W-1:0] winPeak,
  input  logic                toneLive,
  input  logic                toneBit,
  output ctlStrobes_t         strobe,
  output logic                carrierOk,
  output logic                rxBit
);
  localparam int ON_W   = $clog2(ON_BITS + 1);
  localparam int OFF_W  = $clog2(OFF_BITS + 1);
  localparam int TURN_W = $clog2(TURN_BITS + 1);
  localparam logic [SAMPLE_W-1:0] HI_LVL = SAMPLE_W'(HI_TH);
  localparam logic [SAMPLE_W-1:0] LO_LVL = SAMPLE_W'(LO_TH);

  logic              enable;
  logic [TURN_W-1:0] settleCnt, settleNext;
  logic [ON_W-1:0]   onCnt, onNext;
  logic [OFF_W-1:0]  offCnt, offNext;
  logic              cdNext;

  always_comb begin
    enable         = reqSend | fullDuplex;
    strobe.clear   = ~enable;
    strobe.advance = enable & sampleEn;
    settleNext = settleCnt;
    onNext     = onCnt;
    offNext    = offCnt;
    cdNext     = carrierOk;
    if (!enable) begin
      settleNext = '0;
      onNext     = '0;
      offNext    = '0;
      cdNext     = 1'b0;
    end else if (winDone) begin
      if (settleCnt < TURN_W'(TURN_BITS)) begin
        settleNext = settleCnt + 1'b1;
      end else if (!carrierOk) begin
        if (winPeak >= HI_LVL && toneLive) begin
          if (onCnt == ON_W'(ON_BITS - 1)) begin
            cdNext = 1'b1;
            onNext = '0;
          end else begin
            onNext = onCnt + 1'b1;
          end
        end else begin
          onNext = '0;
        end
      end else begin
        if (winPeak < LO_LVL) begin
          if (offCnt == OFF_W'(OFF_BITS - 1)) begin
            cdNext  = 1'b0;
            offNext = '0;
          end else begin
            offNext = offCnt + 1'b1;
          end
        end else begin
          offNext = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      onCnt     <= '0;
      offCnt    <= '0;
      carrierOk <= 1'b0;
      rxBit     <= 1'b1;
    end else begin
      settleCnt <= settleNext;
      onCnt     <= onNext;
      offCnt    <= offNext;
      carrierOk <= cdNext;
      rxBit     <= cdNext ? toneBit : 1'b1;
    end
  end
endmodule

// File: rtl/fskCarrierDemod.sv
module fskCarrierDemod
  import fskDemodPkg::*;
#(
  parameter int SAMPLE_W        = 12,
  parameter int SAMPLES_PER_BIT = 48,
  parameter int LONG_HALF       = 18,
  parameter int MAJ_LEN         = 3,
  parameter int LO_TH           = 400,
  parameter int HI_TH           = 520,
  parameter int ON_BITS         = 3,
  parameter int OFF_BITS        = 3,
  parameter int TURN_BITS       = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleEn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       reqSend,
  input  logic                       fullDuplex,
  output logic                       carrierOk,
  output logic                       rxBit
);
  ctlStrobes_t         strobe;
  logic                winDone;
  logic [SAMPLE_W-1:0] winPeak;
  logic                toneLive;
  logic                toneBit;

  fskDemodPath #(
    .SAMPLE_W(SAMPLE_W), .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .LONG_HALF(LONG_HALF), .MAJ_LEN(MAJ_LEN)
  ) i_path (
    .clk(clk), .rst(rst), .strobe(strobe), .sampleIn(sampleIn),
    .winDone(winDone), .winPeak(winPeak), .toneLive(toneLive), .toneBit(toneBit)
  );

  fskDemodCtrl #(
    .SAMPLE_W(SAMPLE_W), .LO_TH(LO_TH), .HI_TH(HI_TH),
    .ON_BITS(ON_BITS), .OFF_BITS(OFF_BITS), .TURN_BITS(TURN_BITS)
  ) i_ctrl (
    .clk(clk), .rst(rst), .reqSend(reqSend), .fullDuplex(fullDuplex),
    .sampleEn(sampleEn), .winDone(winDone), .winPeak(winPeak),
    .toneLive(toneLive), .toneBit(toneBit), .strobe(strobe),
    .carrierOk(carrierOk), .rxBit(rxBit)
  );
endmodule

// File: rtl/fskCarrierDemodChecks.sv
module fskCarrierDemodChecks #(
  parameter int SAMPLE_W = 12,
  parameter int LO_TH    = 400,
  parameter int HI_TH    = 520
) (
  input logic                clk,
  input logic                rst,
  input logic                reqSend,
  input logic                fullDuplex,
  input logic                carrierOk,
  input logic                rxBit,
  input logic                winDone,
  input logic [SAMPLE_W-1:0] winPeak
);
  // R2: an inactive receiver drops the flag on the next clock
  assert_inactive_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (!reqSend && !fullDuplex) |=> !carrierOk);

  // R8: data idles at mark while no carrier is qualified
  assert_idle_mark_R8: assert property (@(posedge clk) disable iff (rst)
    !carrierOk |-> rxBit);

  // R3 / R6: a rise needs an active receiver and a window at or above the upper level
  assert_rise_needs_peak_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(carrierOk) |-> $past(winDone && winPeak >= SAMPLE_W'(HI_TH) && (reqSend || fullDuplex)));

  // R4 / R7: a fall comes from disable or a window below the lower level
  assert_fall_needs_low_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(carrierOk) |-> $past(!(reqSend || fullDuplex) || (winDone && winPeak < SAMPLE_W'(LO_TH))));

  // R7: between window ends the flag holds while active
  assert_hold_between_windows_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(reqSend || fullDuplex) && !$past(winDone)) |-> $stable(carrierOk));
endmodule

bind fskCarrierDemod fskCarrierDemodChecks #(
  .SAMPLE_W(SAMPLE_W), .LO_TH(LO_TH), .HI_TH(HI_TH)
) i_checks (
  .clk(clk), .rst(rst), .reqSend(reqSend), .fullDuplex(fullDuplex),
  .carrierOk(carrierOk), .rxBit(rxBit), .winDone(winDone), .winPeak(winPeak)
);

// File: tb/test_fskCarrierDemod.sv
module test_fskCarrierDemod;
  localparam int W    = 12;
  localparam int BIT  = 48;
  localparam logic [31:0] STEP_MARK  = 32'd89478485;   // 1200 Hz at 57.6 kS/s
  localparam logic [31:0] STEP_SPACE = 32'd164043890;  // 2200 Hz at 57.6 kS/s

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleEn = 1'b0;
  logic signed [W-1:0] sampleIn = '0;
  logic reqSend = 1'b0;
  logic fullDuplex = 1'b0;
  logic carrierOk;
  logic rxBit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit lowSeen;
  logic [31:0] phase = '0;
  logic [31:0] step = STEP_MARK;
  int amp = 0;

  always #5 clk = ~clk;

  fskCarrierDemod i_fskCarrierDemod (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .reqSend(reqSend), .fullDuplex(fullDuplex), .carrierOk(carrierOk), .rxBit(rxBit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // triangle tone generator, phase continuous across frequency changes
  task automatic runSamples(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rxBit) lowSeen = 1'b1;
      begin
        int p;
        int tri_v;
        phase = phase + step;
        p = int'(phase[31:20]);
        tri_v = (p < 2048) ? (p - 1024) : (3071 - p);
        sampleIn = W'((tri_v * amp) / 1024);
        sampleEn = 1'b1;
      end
    end
  endtask

  task automatic runBits(input int n);
    runSamples(n * BIT);
  endtask

  task automatic sendBit(input bit b);
    step = b ? STEP_MARK : STEP_SPACE;
    runBits(1);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(carrierOk == 1'b0, "R10 reset carrierOk", carrierOk, 0);
    check(rxBit == 1'b1, "R10 reset rxBit", rxBit, 1);
  endtask

  task automatic testSilence();
    reqSend = 1'b1;
    amp = 0;
    runBits(8);
    check(carrierOk == 1'b0, "R6 silent input", carrierOk, 0);
  endtask

  task automatic testAcquire();
    amp = 700;
    step = STEP_MARK;
    runBits(6);
    check(carrierOk == 1'b1, "R3 asserted within 6 bits", carrierOk, 1);
    check(rxBit == 1'b1, "R1 mark decodes 1", rxBit, 1);
  endtask

  task automatic testTones();
    step = STEP_SPACE;
    runBits(2);
    check(rxBit == 1'b0, "R1 space decodes 0", rxBit, 0);
    step = STEP_MARK;
    runBits(2);
    check(rxBit == 1'b1, "R1 mark after space", rxBit, 1);
    for (int k = 0; k < 4; k++) begin
      bit b;
      b = k[0];
      step = b ? STEP_MARK : STEP_SPACE;
      runBits(2);
      check(rxBit == b, "R1 paired bit pattern", rxBit, b);
    end
  endtask

  task automatic testPreamble();
    sendBit(1'b1);
    sendBit(1'b1);
    lowSeen = 1'b0;
    sendBit(1'b0);  // start
    sendBit(1'b1);  // d0
    check(lowSeen == 1'b1, "R9 start bit seen low", lowSeen, 1);
    sendBit(1'b1);
    sendBit(1'b1);
    lowSeen = 1'b0;
    for (int k = 0; k < 5; k++) sendBit(1'b1);
    check(lowSeen == 1'b0, "R9 data ones stay high", lowSeen, 0);
    sendBit(1'b1);  // parity
    sendBit(1'b1);  // stop
    check(carrierOk == 1'b1, "R3 carrier held through frame", carrierOk, 1);
  endtask

  task automatic testHysteresis();
    step = STEP_SPACE;
    amp = 450;
    for (int k = 0; k < 8; k++) begin
      runBits(1);
      check(carrierOk == 1'b1, "R7 mid band holds high", carrierOk, 1);
    end
    amp = 300;
    runBits(6);
    check(carrierOk == 1'b0, "R4 released within 6 bits", carrierOk, 0);
    check(rxBit == 1'b1, "R8 space below threshold idles high", rxBit, 1);
    amp = 450;
    for (int k = 0; k < 8; k++) begin
      runBits(1);
      check(carrierOk == 1'b0, "R7 mid band holds low", carrierOk, 0);
    end
    amp = 300;
    for (int k = 0; k < 6; k++) begin
      runBits(1);
      check(carrierOk == 1'b0, "R6 below lower level", carrierOk, 0);
      check(rxBit == 1'b1, "R8 idle mark", rxBit, 1);
    end
  endtask

  task automatic testLoss();
    amp = 700;
    step = STEP_MARK;
    runBits(6);
    check(carrierOk == 1'b1, "R3 reacquire", carrierOk, 1);
    amp = 0;
    runBits(6);
    check(carrierOk == 1'b0, "R4 carrier removed", carrierOk, 0);
    check(rxBit == 1'b1, "R8 idle after loss", rxBit, 1);
  endtask

  task automatic testDisable();
    amp = 700;
    step = STEP_SPACE;
    runBits(6);
    check(carrierOk == 1'b1, "R3 before disable", carrierOk, 1);
    reqSend = 1'b0;
    runSamples(1);
    check(carrierOk == 1'b0, "R2 disable next cycle", carrierOk, 0);
    check(rxBit == 1'b1, "R2 disable rxBit", rxBit, 1);
    runBits(6);
    check(carrierOk == 1'b0, "R2 stays off while inactive", carrierOk, 0);
  endtask

  task automatic testTurnaround();
    step = STEP_MARK;
    reqSend = 1'b1;
    runSamples(3 * BIT);
    check(carrierOk == 1'b0, "R5 settle keeps flag low", carrierOk, 0);
    runSamples(7 * BIT);
    check(carrierOk == 1'b1, "R5 asserted within 10 bits", carrierOk, 1);
  endtask

  task automatic testDuplex();
    reqSend = 1'b0;
    runSamples(2);
    fullDuplex = 1'b1;
    runBits(10);
    check(carrierOk == 1'b1, "R2 duplex enables receive", carrierOk, 1);
    check(rxBit == 1'b1, "R1 duplex mark", rxBit, 1);
    reqSend = 1'b1;
    runBits(1);
    reqSend = 1'b0;
    runBits(2);
    check(carrierOk == 1'b1, "R2 duplex ignores reqSend", carrierOk, 1);
  endtask

  initial begin
    testReset();
    testSilence();
    testAcquire();
    testTones();
    testPreamble();
    testHysteresis();
    testLoss();
    testDisable();
    testTurnaround();
    testDuplex();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule